// File: doc/BRIEF.md
# Serial Bitstream Configuration Loader

This block programs a target device that accepts its configuration as a serial bit stream. A host pulses `start_i` with a byte count and then supplies the bytes over a valid/ready stream. The loader runs the target's reset handshake on its PROGRAM and INIT lines. It then shifts every byte out on DIN with a paced configuration clock and finally clocks the target until the target raises DONE.

Each wait phase has a cycle-count timeout. While data is flowing, the loader treats INIT going active with DONE still low as a checksum error reported by the target. The run ends with one result code on `status_o`. The code is held until the next start. The pacing interval and the timeout length are parameters, so the clock rate and the wait limit can be fitted to the target and to the system clock. A 10 ms limit at 200 MHz is the default.

Top module: `serial_cfg_loader`

## Requirements
- R1: A `start_i` pulse while idle drives `prog_no` low and `busy_o` high and clears `status_o` to 0 on the next clock.
- R2: With PROGRAM asserted, the loader waits for `init_ni` to go low. If `init_ni` stays high for TIMEOUT_CYC cycles, the run ends with `status_o` = 2.
- R3: After `init_ni` goes low, PROGRAM is released one pacing interval later and the loader waits for `init_ni` to go high. If `init_ni` stays low for TIMEOUT_CYC cycles, the run ends with `status_o` = 3.
- R4: Each byte goes out most significant bit first, one bit per rising edge of `cclk_o`, with eight rising edges per byte. `din_o` changes only while `cclk_o` is low and never in the cycle of a rising edge.
- R5: During a run, two successive transitions of `cclk_o` are at least PACE_CYC cycles apart.
- R6: Exactly `byte_count_i` bytes are taken, each on a cycle with `ready_o` and `valid_i` both high. `ready_o` is high only between bytes, after all eight bits of the previous byte have been clocked out.
- R7: Before each byte, if `init_ni` is low while `done_i` is low, the run stops with `status_o` = 4 and no further byte is taken.
- R8: After the last byte, `din_o` is held high and `cclk_o` keeps toggling until `done_i` is high. The run then ends with `status_o` = 1.
- R9: If `done_i` does not go high within TIMEOUT_CYC cycles of the final phase, the run ends with `status_o` = 5.
- R10: When not busy, `prog_no` is high, `cclk_o` is low and `status_o` holds its value until the next start. A `start_i` pulse during a run has no effect.
- R11: A byte count of zero skips the data phase and goes straight to the final clocking phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, sampled while idle |
| byte_count_i | input | CNT_W | Number of bytes to send, sampled at start |
| byte_i | input | 8 | Stream data byte |
| valid_i | input | 1 | Stream byte valid |
| ready_o | output | 1 | Loader takes a byte this cycle when valid_i is high |
| prog_no | output | 1 | Target PROGRAM line, active low |
| cclk_o | output | 1 | Configuration clock to the target |
| din_o | output | 1 | Serial data to the target |
| init_ni | input | 1 | Target INIT line, active low |
| done_i | input | 1 | Target DONE line, high when configured |
| busy_o | output | 1 | A run is in progress |
| status_o | output | 3 | Result: 0 none, 1 ok, 2 INIT start timeout, 3 INIT clear timeout, 4 checksum error, 5 DONE timeout |

## Verification
The assertions assume that `init_ni` and `done_i` are already synchronous to `clk_i`. They also assume that the host holds `byte_i` stable while `valid_i` waits for `ready_o`. The bench drives both target lines and the stream only at falling clock edges. Its target model raises DONE only after INIT has cleared and PROGRAM has been released. It presents the byte at the current stream index for as long as that byte has not been taken.

// File: rtl/scl_pkg.sv
package scl_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PROG,
    ST_REL,
    ST_CLEAR,
    ST_NEXT,
    ST_LOW,
    ST_DATA,
    ST_HIGH,
    ST_TAIL
  } st_e;

  typedef enum logic [2:0] {
    RES_NONE       = 3'd0,
    RES_OK         = 3'd1,
    RES_INIT_START = 3'd2,
    RES_INIT_CLEAR = 3'd3,
    RES_CRC        = 3'd4,
    RES_DONE_TO    = 3'd5
  } res_e;
endpackage

// File: rtl/scl_pacer.sv
module scl_pacer #(
  parameter int unsigned PACE_CYC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic step_o
);
  localparam int unsigned PW = (PACE_CYC > 1) ? $clog2(PACE_CYC) : 1;
  localparam logic [PW-1:0] LAST = PW'(PACE_CYC - 1);

  logic [PW-1:0] cnt_q;

  assign step_o = run_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!run_i || step_o)  cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/scl_timer.sv
module scl_timer #(
  parameter int unsigned LIMIT = 2000000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic expired_o
);
  localparam int unsigned CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] END_V = CW'(LIMIT);

  logic [CW-1:0] cnt_q;

  assign expired_o = en_i && (cnt_q == END_V);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (!en_i)           cnt_q <= '0;
    else if (cnt_q != END_V)  cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/scl_shifter.sv
module scl_shifter
  import scl_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              adv_i,
  output logic              bit_o,
  output logic              last_o
);
  localparam int unsigned BW = $clog2(BYTE_W);
  localparam logic [BW-1:0] TOP = BW'(BYTE_W - 1);

  logic [BYTE_W-1:0] sh_q;
  logic [BW-1:0]     cnt_q;

  assign bit_o  = sh_q[BYTE_W-1];
  assign last_o = (cnt_q == TOP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (load_i) begin
      sh_q  <= byte_i;
      cnt_q <= '0;
    end else if (adv_i) begin
      sh_q  <= {sh_q[BYTE_W-2:0], 1'b0};
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // a new byte only enters after the bit counter has wrapped
  assert_load_on_wrap_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> (cnt_q == '0));
  assert_no_load_mid_bit_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(load_i && adv_i));
  assert_wrap_after_last_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && last_o) |=> (cnt_q == '0));
endmodule

// File: rtl/serial_cfg_loader.sv
module serial_cfg_loader
  import scl_pkg::*;
#(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned PACE_CYC    = 4,
  parameter int unsigned TIMEOUT_CYC = 2000000
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  start_i,
  input  logic [CNT_W-1:0]      byte_count_i,
  input  logic [BYTE_W-1:0]     byte_i,
  input  logic                  valid_i,
  output logic                  ready_o,
  output logic                  prog_no,
  output logic                  cclk_o,
  output logic                  din_o,
  input  logic                  init_ni,
  input  logic                  done_i,
  output logic                  busy_o,
  output logic [2:0]            status_o
);
  st_e              st_q;
  res_e             res_q;
  logic [CNT_W-1:0] rem_q;
  logic             prog_n_q, cclk_q, din_q;

  logic step, tmo, sh_bit, sh_last, load, adv, crc_hit, run, tmr_en;

  assign run     = st_q inside {ST_REL, ST_LOW, ST_DATA, ST_HIGH, ST_TAIL};
  assign tmr_en  = st_q inside {ST_PROG, ST_CLEAR, ST_TAIL};
  assign crc_hit = !init_ni && !done_i;
  assign ready_o = (st_q == ST_NEXT) && (rem_q != '0) && !crc_hit;
  assign load    = ready_o && valid_i;
  assign adv     = (st_q == ST_HIGH) && step;

  assign prog_no  = prog_n_q;
  assign cclk_o   = cclk_q;
  assign din_o    = din_q;
  assign busy_o   = (st_q != ST_IDLE);
  assign status_o = res_q;

  scl_pacer #(.PACE_CYC(PACE_CYC)) u_pacer (
    .clk_i (clk_i), .rst_ni(rst_ni), .run_i(run), .step_o(step)
  );

  scl_timer #(.LIMIT(TIMEOUT_CYC)) u_timer (
    .clk_i (clk_i), .rst_ni(rst_ni), .en_i(tmr_en), .expired_o(tmo)
  );

  scl_shifter u_shift (
    .clk_i (clk_i), .rst_ni(rst_ni), .load_i(load), .byte_i(byte_i),
    .adv_i (adv), .bit_o(sh_bit), .last_o(sh_last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      res_q    <= RES_NONE;
      rem_q    <= '0;
      prog_n_q <= 1'b1;
      cclk_q   <= 1'b0;
      din_q    <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          prog_n_q <= 1'b0;
          cclk_q   <= 1'b0;
          din_q    <= 1'b0;
          res_q    <= RES_NONE;
          rem_q    <= byte_count_i;
          st_q     <= ST_PROG;
        end
        ST_PROG: begin
          if (!init_ni) st_q <= ST_REL;
          else if (tmo) begin
            st_q     <= ST_IDLE;
            prog_n_q <= 1'b1;
            res_q    <= RES_INIT_START;
          end
        end
        ST_REL: if (step) begin
          prog_n_q <= 1'b1;
          st_q     <= ST_CLEAR;
        end
        ST_CLEAR: begin
          if (init_ni) st_q <= ST_NEXT;
          else if (tmo) begin
            st_q  <= ST_IDLE;
            res_q <= RES_INIT_CLEAR;
          end
        end
        ST_NEXT: begin
          if (rem_q == '0) begin
            din_q <= 1'b1;
            st_q  <= ST_TAIL;
          end else if (crc_hit) begin
            st_q   <= ST_IDLE;
            cclk_q <= 1'b0;
            din_q  <= 1'b0;
            res_q  <= RES_CRC;
          end else if (valid_i) begin
            rem_q <= rem_q - 1'b1;
            st_q  <= ST_LOW;
          end
        end
        ST_LOW: if (step) begin
          cclk_q <= 1'b0;
          st_q   <= ST_DATA;
        end
        ST_DATA: if (step) begin
          din_q <= sh_bit;
          st_q  <= ST_HIGH;
        end
        ST_HIGH: if (step) begin
          cclk_q <= 1'b1;
          st_q   <= sh_last ? ST_NEXT : ST_LOW;
        end
        ST_TAIL: begin
          if (done_i || tmo) begin
            st_q   <= ST_IDLE;
            cclk_q <= 1'b0;
            din_q  <= 1'b0;
            res_q  <= done_i ? RES_OK : RES_DONE_TO;
          end else if (step) begin
            cclk_q <= ~cclk_q;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // clock spacing monitor for R5
  localparam int unsigned GW = $clog2(PACE_CYC + 1);
  logic          cclk_prev_q;
  logic [GW-1:0] gap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cclk_prev_q <= 1'b0;
      gap_q       <= GW'(PACE_CYC);
    end else begin
      cclk_prev_q <= cclk_q;
      if (cclk_q != cclk_prev_q)     gap_q <= GW'(1);
      else if (gap_q != GW'(PACE_CYC)) gap_q <= gap_q + 1'b1;
    end
  end

  assert_start_prog_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i) |=> (!prog_no && busy_o && status_o == RES_NONE));
  assert_init_start_to_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_PROG && init_ni && tmo) |=> (status_o == RES_INIT_START && !busy_o));
  assert_init_clear_to_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_CLEAR && !init_ni && tmo) |=> (status_o == RES_INIT_CLEAR));
  assert_prog_held_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_CLEAR) |-> prog_no);
  assert_din_stable_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cclk_o) |-> $stable(din_o));
  assert_cclk_gap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && cclk_q != cclk_prev_q) |-> (gap_q >= GW'(PACE_CYC)));
  assert_crc_stop_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_NEXT && rem_q != '0 && crc_hit) |=> (status_o == RES_CRC && !busy_o));
  assert_tail_din_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_TAIL) |-> din_o);
  assert_done_ok_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_TAIL && done_i) |=> (status_o == RES_OK && !busy_o));
  assert_done_to_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_TAIL && !done_i && tmo) |=> (status_o == RES_DONE_TO));
  assert_idle_pins_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (prog_no && !cclk_o && !ready_o));
  assert_status_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> $stable(status_o));
endmodule

// File: tb/serial_cfg_loader_tb_top.sv
module serial_cfg_loader_tb_top;
  localparam int PACE = 2;
  localparam int TMO  = 400;
  localparam int CW   = 8;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst_ni, start_i, valid_i, init_ni, done_i;
  logic [CW-1:0] byte_count_i;
  logic [7:0]    byte_i;
  logic          ready_o, prog_no, cclk_o, din_o, busy_o;
  logic [2:0]    status_o;

  serial_cfg_loader #(.CNT_W(CW), .PACE_CYC(PACE), .TIMEOUT_CYC(TMO)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .byte_count_i(byte_count_i),
    .byte_i(byte_i), .valid_i(valid_i), .ready_o(ready_o), .prog_no(prog_no),
    .cclk_o(cclk_o), .din_o(din_o), .init_ni(init_ni), .done_i(done_i),
    .busy_o(busy_o), .status_o(status_o)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  // target model configuration and observations
  int cfg_n = 0, cfg_idly = 0, cfg_cdly = 0, cfg_dafter = -1, cfg_crcb = -1;
  int plow, chigh, rises, gap, gapviol, unstable, tail_bad, hs_cnt, idx;
  bit crc_fired, hs_pending, prog_seen;
  logic cclk_last, din_last;
  logic [7:0] pay [64];
  logic [7:0] cap [64];

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_status(int n, int idly, int cdly, int dafter, int crcb);
    if (idly < 0) return 2;
    if (cdly < 0) return 3;
    if (crcb >= 0 && crcb < n - 1) return 4;
    if (dafter < 0) return 5;
    return 1;
  endfunction

  function automatic int exp_bytes(int n, int idly, int cdly, int crcb);
    if (idly < 0 || cdly < 0) return 0;
    if (crcb >= 0 && crcb < n - 1) return crcb + 1;
    return n;
  endfunction

  initial begin
    wait (rst_ni === 1'b1);
    forever begin
      @(negedge clk);
      if (hs_pending) begin hs_cnt++; idx++; end
      gap++;
      if (busy_o && cclk_o != cclk_last) begin
        if (gap < PACE) gapviol++;
        gap = 0;
      end
      if (cclk_o && !cclk_last) begin
        if (din_o != din_last) unstable++;
        if (rises < cfg_n * 8) cap[rises/8] = {cap[rises/8][6:0], din_o};
        else if (!din_o) tail_bad++;
        rises++;
      end
      cclk_last = cclk_o;
      din_last  = din_o;
      if (!prog_no) begin
        prog_seen = 1; plow++; chigh = 0; done_i = 0;
        if (cfg_idly >= 0 && plow > cfg_idly) init_ni = 0;
      end else if (prog_seen && !crc_fired && !init_ni) begin
        chigh++;
        if (cfg_cdly >= 0 && chigh > cfg_cdly) init_ni = 1;
      end
      if (cfg_crcb >= 0 && rises >= cfg_crcb * 8 + 4) begin crc_fired = 1; init_ni = 0; end
      if (cfg_dafter >= 0 && prog_seen && prog_no && init_ni && rises >= cfg_n * 8 + cfg_dafter)
        done_i = 1;
      if (idx < cfg_n) begin
        valid_i = ($urandom % 4) != 0;
        byte_i  = pay[idx];
      end else valid_i = 0;
      #1;
      hs_pending = ready_o && valid_i;
    end
  end

  task automatic run_case(string name, int n, int idly, int cdly, int dafter, int crcb,
                          bit directed, bit poke);
    int cyc, est, eb, bad;
    @(posedge clk); #1;
    cfg_n = n; cfg_idly = idly; cfg_cdly = cdly; cfg_dafter = dafter; cfg_crcb = crcb;
    plow = 0; chigh = 0; rises = 0; gap = 1000; gapviol = 0; unstable = 0; tail_bad = 0;
    hs_cnt = 0; idx = 0; crc_fired = 0; hs_pending = 0; prog_seen = 0;
    init_ni = 1; done_i = 0; valid_i = 0;
    cclk_last = cclk_o; din_last = din_o;
    for (int i = 0; i < n; i++) begin
      if (directed) begin
        case (i % 5)
          0: pay[i] = 8'h80;
          1: pay[i] = 8'h01;
          2: pay[i] = 8'hFF;
          3: pay[i] = 8'h00;
          default: pay[i] = 8'hA5;
        endcase
      end else pay[i] = 8'($urandom);
      cap[i] = 8'h00;
    end
    start_i = 1; byte_count_i = CW'(n);
    @(posedge clk); #1;
    start_i = 0;
    check(!prog_no && busy_o && status_o == 3'd0, {"R1 start ", name},
          {prog_no, busy_o, status_o}, 32'b01000);
    cyc = 0;
    while (busy_o && cyc < 20000) begin
      @(posedge clk); #1;
      cyc++;
      if (poke && cyc == 40) begin start_i = 1; byte_count_i = CW'(1); end
      else start_i = 0;
    end
    start_i = 0;
    est = exp_status(n, idly, cdly, dafter, crcb);
    eb  = exp_bytes(n, idly, cdly, crcb);
    check(int'(status_o) == est, {"R2 R3 R7 R8 R9 status ", name}, status_o, est);
    check(hs_cnt == eb, {"R6 bytes taken ", name}, hs_cnt, eb);
    bad = 0;
    for (int i = 0; i < eb; i++) if (cap[i] !== pay[i]) bad++;
    check(bad == 0, {"R4 MSB-first data ", name}, bad, 0);
    if (eb > 0 || est == 1)
      check(rises >= eb * 8, {"R4 eight edges per byte ", name}, rises, eb * 8);
    check(unstable == 0, {"R4 din stable at rise ", name}, unstable, 0);
    check(gapviol == 0, {"R5 cclk spacing ", name}, gapviol, 0);
    if (est == 1 || est == 5)
      check(tail_bad == 0, {"R8 din high in final phase ", name}, tail_bad, 0);
    if (idly < 0)
      check(cyc >= TMO - 2 && cyc <= TMO + 4, {"R2 timeout length ", name}, cyc, TMO);
    if (est == 5)
      check(rises > eb * 8 + 4, {"R9 clocks while waiting ", name}, rises, eb * 8 + 5);
    repeat (3) @(posedge clk);
    #1;
    check(prog_no && !cclk_o && !busy_o && int'(status_o) == est,
          {"R10 idle hold ", name}, {prog_no, cclk_o, busy_o, status_o}, {3'b100, 3'(est)});
  endtask

  initial begin
    rst_ni = 0; start_i = 0; valid_i = 0; init_ni = 1; done_i = 0;
    byte_count_i = '0; byte_i = '0;
    void'($urandom(32'h5eed));
    repeat (4) @(posedge clk);
    #1;
    check(prog_no && !cclk_o && !busy_o && !ready_o && status_o == 3'd0,
          "R10 reset state", {prog_no, cclk_o, busy_o, ready_o, status_o}, 32'b1000000);
    rst_ni = 1;
    repeat (2) @(posedge clk);
    run_case("directed", 5, 3, 5, 6, -1, 1, 0);
    run_case("poke_busy_R10", 12, 10, 2, 1, -1, 0, 1);
    run_case("zero_count_R11", 0, 2, 2, 3, -1, 0, 0);
    run_case("init_start_to", 3, -1, 2, 2, -1, 0, 0);
    run_case("init_clear_to", 3, 2, -1, 2, -1, 0, 0);
    run_case("crc_error", 6, 2, 3, 2, 2, 0, 0);
    run_case("done_to", 3, 2, 3, -1, -1, 1, 0);
    run_case("done_at_once", 4, 1, 1, 0, -1, 0, 0);
    for (int k = 0; k < 4; k++)
      run_case("random", 1 + int'($urandom % 16), int'($urandom % 20), int'($urandom % 20),
               int'($urandom % 10), -1, 0, 0);
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule